// File: doc/BRIEF.md
# Teaching Peripheral Register Block

This block is the register front end of a small teaching peripheral. It sits behind a simple memory-mapped bus whose requests carry an offset, a write-data word of 64 bits, an access size in bytes and a read/write flag. Each accepted request completes in one cycle. A read returns its data through a registered response one cycle later. It holds a fixed identification word, a check register that returns the complement of what was written, an operand/result register for a factorial engine, a status word, an interrupt status with separate set and clear offsets, and four stored DMA descriptor words.

Software starts a factorial by writing the operand. The included iterative engine then does one multiply per cycle and writes the wrapped 32-bit result back. It can also flag an interrupt when it finishes. The DMA words are only stored and read back here; no transfer engine is attached.

Top module: `tdev_regs`

## Requirements
- R1: Offsets below 0x80 accept only 4-byte accesses. Offsets 0x80 and above accept 4-byte and 8-byte accesses. A write with any other size changes no register.
- R2: A read with an illegal size, or a read of an offset that maps to nothing (for example 0x40, 0x84, or a write-only offset such as 0x60), returns all 64 bits set to one.
- R3: Offset 0x00 reads 0x010000ED, zero-extended. Writes to it have no effect.
- R4: A write to offset 0x04 stores the bitwise complement of the low 32 data bits. Reading 0x04 returns the stored word, zero-extended. It resets to 0.
- R5: A write to 0x08 while status bit 0 (computing) is clear loads the operand and sets computing. While computing is set, writes to 0x08 are dropped. Reading 0x08 returns the register.
- R6: On completion, 0x08 holds n! modulo 2^32, with 0! = 1, and computing clears.
- R7: Writing 0x20 copies data bit 7 into status bit 7 (completion interrupt enable). Reading 0x20 returns computing in bit 0, the enable in bit 7, and zeros elsewhere.
- R8: When a computation finishes with the enable set, bit 0 of the interrupt status is set. With the enable clear, the interrupt status is left unchanged.
- R9: A write to 0x60 ORs the data into the 32-bit interrupt status. A write to 0x64 clears the data's one bits. Offset 0x24 reads the status. The interrupt output is high exactly while the status is nonzero.
- R10: Offsets 0x80, 0x88, 0x90 and 0x98 hold the DMA source, destination, count and command. An 8-byte write replaces all 64 bits. A 4-byte write replaces the low 32 bits and keeps the high 32. A 4-byte read returns the low 32 bits, zero-extended.
- R11: A write to 0x98 whose bit 0 (run) is clear is ignored.
- R12: After reset, the status, interrupt status, check register and interrupt output are all zero. The request ready output is always high. Every read gets a response valid exactly one cycle after it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset within the block |
| req_size | input | 4 | Access size in bytes |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 64 | Read data |
| irq_o | output | 1 | Interrupt line |

## Verification
Register writes take effect at the accepting edge. The bench drives each request on a falling edge and samples on the next falling edge, so state written at that edge can be read back at once. Read data comes out of a register one cycle after acceptance; the read task samples it half a cycle after that edge. The interrupt line follows the interrupt status with no extra register, so it is checked immediately after the raising or lowering write. Factorial latency depends on the operand, so the bench polls status bit 0 with a bounded loop and only then compares the result with a product it computes itself, for every operand from 0 to 13.

// File: rtl/tdev_pkg.sv
package tdev_pkg;
    localparam int ADDR_W  = 8;
    localparam int SIZE_W  = 4;
    localparam int WIDE_W  = 64;
    localparam int REG_W   = 32;
    localparam int DMA_N   = 4;

    localparam logic [ADDR_W-1:0] OFF_ID    = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_CHK   = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_FACT  = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_STAT  = 8'h20;
    localparam logic [ADDR_W-1:0] OFF_ISTAT = 8'h24;
    localparam logic [ADDR_W-1:0] OFF_RAISE = 8'h60;
    localparam logic [ADDR_W-1:0] OFF_LOWER = 8'h64;
    localparam logic [ADDR_W-1:0] OFF_DMA   = 8'h80;
    localparam logic [ADDR_W-1:0] WIDE_BASE = 8'h80;

    localparam logic [REG_W-1:0]  ID_WORD   = 32'h0100_00ED;
    localparam int BIT_BUSY  = 0;
    localparam int BIT_IEN   = 7;
    localparam int BIT_RUN   = 0;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [SIZE_W-1:0] size;
        logic [WIDE_W-1:0] data;
    } bus_req_t;

    function automatic logic size_ok(input logic [ADDR_W-1:0] a,
                                     input logic [SIZE_W-1:0] s);
        if (a < WIDE_BASE) return (s == SIZE_W'(4));
        return (s == SIZE_W'(4)) || (s == SIZE_W'(8));
    endfunction

    function automatic logic [ADDR_W-1:0] dma_off(input int idx);
        return OFF_DMA + ADDR_W'(idx * 8);
    endfunction
endpackage

// File: rtl/tdev_size_check.sv
module tdev_size_check
    import tdev_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [SIZE_W-1:0] size,
    output logic              legal
);
    assign legal = size_ok(addr, size);
endmodule

// File: rtl/tdev_fact_unit.sv
module tdev_fact_unit
    import tdev_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [REG_W-1:0] operand,
    output logic             done,
    output logic [REG_W-1:0] result
);
    logic             running;
    logic [REG_W-1:0] acc;
    logic [REG_W-1:0] cnt;

    assign done   = running && (cnt <= REG_W'(1));
    assign result = acc;

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            acc     <= '0;
            cnt     <= '0;
        end else if (start) begin
            running <= 1'b1;
            acc     <= REG_W'(1);
            cnt     <= operand;
        end else if (running) begin
            if (done) begin
                running <= 1'b0;
            end else begin
                acc <= acc * cnt;
                cnt <= cnt - REG_W'(1);
            end
        end
    end
endmodule

// File: rtl/tdev_irq_ctrl.sv
module tdev_irq_ctrl
    import tdev_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             set_we,
    input  logic             clr_we,
    input  logic [REG_W-1:0] bits,
    input  logic             done_set,
    output logic [REG_W-1:0] stat,
    output logic             irq
);
    logic [REG_W-1:0] stat_n;

    always_comb begin
        stat_n = stat;
        if (clr_we) stat_n = stat_n & ~bits;
        if (set_we) stat_n = stat_n | bits;
        if (done_set) stat_n = stat_n | REG_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) stat <= '0;
        else     stat <= stat_n;
    end

    assign irq = |stat;
endmodule

// File: rtl/tdev_regs.sv
module tdev_regs
    import tdev_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [SIZE_W-1:0] req_size,
    input  logic [WIDE_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [WIDE_W-1:0] rsp_rdata,
    output logic              irq_o
);
    localparam int HI_W = WIDE_W - REG_W;

    bus_req_t         req;
    logic             legal;
    logic             wr_go;
    logic             rd_go;
    logic [REG_W-1:0] chk_q;
    logic [REG_W-1:0] fact_q;
    logic             busy;
    logic             irq_en;
    logic             fact_start;
    logic             fact_done;
    logic [REG_W-1:0] fact_res;
    logic [REG_W-1:0] istat;
    logic [REG_W-1:0] stat_word;
    logic [DMA_N-1:0] dma_we;
    logic [DMA_N-1:0][WIDE_W-1:0] dma_q;
    logic [WIDE_W-1:0] rd_val;

    assign req = '{wr: req_write, addr: req_addr, size: req_size, data: req_wdata};
    assign req_ready = 1'b1;

    tdev_size_check u_size (.addr(req.addr), .size(req.size), .legal(legal));

    assign wr_go      = req_valid && req.wr && legal;
    assign rd_go      = req_valid && !req.wr;
    assign fact_start = wr_go && (req.addr == OFF_FACT) && !busy;

    tdev_fact_unit u_fact (
        .clk(clk), .rst(rst), .start(fact_start),
        .operand(req.data[REG_W-1:0]), .done(fact_done), .result(fact_res)
    );

    tdev_irq_ctrl u_irq (
        .clk(clk), .rst(rst),
        .set_we(wr_go && (req.addr == OFF_RAISE)),
        .clr_we(wr_go && (req.addr == OFF_LOWER)),
        .bits(req.data[REG_W-1:0]),
        .done_set(fact_done && irq_en),
        .stat(istat), .irq(irq_o)
    );

    genvar g;
    generate
        for (g = 0; g < DMA_N; g++) begin : g_dma_we
            if (g == DMA_N - 1) begin : g_cmd
                assign dma_we[g] = wr_go && (req.addr == dma_off(g)) && req.data[BIT_RUN];
            end else begin : g_plain
                assign dma_we[g] = wr_go && (req.addr == dma_off(g));
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            chk_q  <= '0;
            fact_q <= '0;
            busy   <= 1'b0;
            irq_en <= 1'b0;
            dma_q  <= '0;
        end else begin
            if (wr_go && req.addr == OFF_CHK) chk_q <= ~req.data[REG_W-1:0];
            if (wr_go && req.addr == OFF_STAT) irq_en <= req.data[BIT_IEN];
            if (fact_start) begin
                fact_q <= req.data[REG_W-1:0];
                busy   <= 1'b1;
            end else if (fact_done) begin
                fact_q <= fact_res;
                busy   <= 1'b0;
            end
            for (int i = 0; i < DMA_N; i++) begin
                if (dma_we[i]) begin
                    if (req.size == SIZE_W'(8)) dma_q[i] <= req.data;
                    else dma_q[i][REG_W-1:0] <= req.data[REG_W-1:0];
                end
            end
        end
    end

    always_comb begin
        stat_word = '0;
        stat_word[BIT_BUSY] = busy;
        stat_word[BIT_IEN]  = irq_en;
    end

    always_comb begin
        rd_val = '1;
        if (legal) begin
            case (req.addr)
                OFF_ID:    rd_val = {{HI_W{1'b0}}, ID_WORD};
                OFF_CHK:   rd_val = {{HI_W{1'b0}}, chk_q};
                OFF_FACT:  rd_val = {{HI_W{1'b0}}, fact_q};
                OFF_STAT:  rd_val = {{HI_W{1'b0}}, stat_word};
                OFF_ISTAT: rd_val = {{HI_W{1'b0}}, istat};
                default:   rd_val = '1;
            endcase
            for (int i = 0; i < DMA_N; i++) begin
                if (req.addr == dma_off(i)) begin
                    if (req.size == SIZE_W'(8)) rd_val = dma_q[i];
                    else rd_val = {{HI_W{1'b0}}, dma_q[i][REG_W-1:0]};
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= rd_go;
            if (rd_go) rsp_rdata <= rd_val;
        end
    end
endmodule

// File: rtl/tdev_regs_checker.sv
module tdev_regs_checker
    import tdev_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [SIZE_W-1:0] req_size,
    input logic [WIDE_W-1:0] req_wdata,
    input logic              rsp_valid,
    input logic [WIDE_W-1:0] rsp_rdata,
    input logic              irq_o,
    input logic              busy,
    input logic              fact_done,
    input logic [REG_W-1:0]  fact_q
);
    assert_reject_ones_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && !size_ok(req_addr, req_size))
        |=> (rsp_valid && rsp_rdata == '1));

    assert_id_word_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && req_addr == OFF_ID && req_size == SIZE_W'(4))
        |=> (rsp_rdata == WIDE_W'(ID_WORD)));

    assert_start_busy_R5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && req_addr == OFF_FACT && req_size == SIZE_W'(4) && !busy)
        |=> busy);

    assert_drop_when_busy_R5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && req_addr == OFF_FACT && busy && !fact_done)
        |=> (busy && fact_q == $past(fact_q)));

    assert_raise_line_R9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && req_addr == OFF_RAISE && req_size == SIZE_W'(4)
         && req_wdata[REG_W-1:0] != '0) |=> irq_o);

    assert_read_resp_R12: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write) |=> rsp_valid);

    assert_no_spurious_resp_R12: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && !req_write) |=> !rsp_valid);
endmodule

bind tdev_regs tdev_regs_checker u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq_o(irq_o),
    .busy(busy), .fact_done(fact_done), .fact_q(fact_q)
);

// File: tb/tdev_regs_bench.sv
module tdev_regs_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [3:0]  req_size = '0;
    logic [63:0] req_wdata = '0;
    logic        rsp_valid;
    logic [63:0] rsp_rdata;
    logic        irq_o;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

    always #2 clk = ~clk;

    tdev_regs u_tdev_regs (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .irq_o(irq_o)
    );

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [3:0] s, input logic [63:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_size = s; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [3:0] s, output logic [63:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_size = s;
        @(negedge clk);
        req_valid = 1'b0;
        check("R12 response valid", {63'b0, rsp_valid}, 64'd1);
        d = rsp_rdata;
    endtask

    task automatic wait_idle();
        logic [63:0] st;
        for (int k = 0; k < 200; k++) begin
            rd(8'h20, 4'd4, st);
            if (st[0] == 1'b0) return;
        end
        check("R6 computation finished", st & 64'h1, 64'h0);
    endtask

    function automatic logic [31:0] fact_ref(input int n);
        logic [31:0] p = 32'd1;
        for (int k = 2; k <= n; k++) p = p * 32'(k);
        return p;
    endfunction

    initial begin
        #150000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: got=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R12 reset state
        check("R12 ready high", {63'b0, req_ready}, 64'd1);
        check("R12 irq low after reset", {63'b0, irq_o}, 64'd0);
        rd(8'h20, 4'd4, v); check("R12 status reset", v, 64'd0);
        rd(8'h24, 4'd4, v); check("R12 irq status reset", v, 64'd0);
        rd(8'h04, 4'd4, v); check("R12 check reg reset", v, 64'd0);

        // R3 identification
        rd(8'h00, 4'd4, v); check("R3 id word", v, 64'h0000_0000_0100_00ED);
        wr(8'h00, 4'd4, 64'h1234);
        rd(8'h00, 4'd4, v); check("R3 id read-only", v, 64'h0000_0000_0100_00ED);

        // R4 check register sweep
        for (int k = 0; k < 8; k++) begin
            logic [31:0] pat = 32'h0000_0001 << (k * 4) ^ 32'hA5A5_0F0F;
            wr(8'h04, 4'd4, {32'hDEAD_BEEF, pat});
            rd(8'h04, 4'd4, v); check("R4 complement stored", v, {32'h0, ~pat});
        end

        // R1 illegal sizes are ignored
        wr(8'h04, 4'd4, 64'h0000_0000_FFFF_0000);
        for (int s = 0; s < 16; s++) begin
            if (s != 4) wr(8'h04, 4'(s), 64'h0);
        end
        rd(8'h04, 4'd4, v); check("R1 low region size filter", v, 64'h0000_FFFF);
        wr(8'h80, 4'd8, 64'h1111_2222_3333_4444);
        wr(8'h80, 4'd2, 64'h0);
        wr(8'h80, 4'd1, 64'h0);
        rd(8'h80, 4'd8, v); check("R1 wide region size filter", v, 64'h1111_2222_3333_4444);

        // R2 rejected and unmapped reads
        rd(8'h00, 4'd8, v); check("R2 wide read of low region", v, ONES);
        rd(8'h80, 4'd2, v); check("R2 bad size in wide region", v, ONES);
        rd(8'h40, 4'd4, v); check("R2 unmapped 0x40", v, ONES);
        rd(8'h84, 4'd4, v); check("R2 unmapped 0x84", v, ONES);
        rd(8'h60, 4'd4, v); check("R2 write-only 0x60", v, ONES);

        // R10 DMA descriptors
        for (int i = 0; i < 4; i++) begin
            logic [63:0] w = {32'hA000_0000 + 32'(i), 32'h0B00_0001 + 32'(i * 2)};
            wr(8'h80 + 8'(i * 8), 4'd8, w);
            rd(8'h80 + 8'(i * 8), 4'd8, v); check("R10 wide store", v, w);
            wr(8'h80 + 8'(i * 8), 4'd4, 64'hFFFF_FFFF_0000_0C03);
            rd(8'h80 + 8'(i * 8), 4'd8, v); check("R10 narrow keeps high", v, {w[63:32], 32'h0000_0C03});
            rd(8'h80 + 8'(i * 8), 4'd4, v); check("R10 narrow read", v, 64'h0000_0C03);
        end

        // R11 command without run bit
        wr(8'h98, 4'd8, 64'h5);
        wr(8'h98, 4'd8, 64'hFFFF_0000_0000_00FE);
        rd(8'h98, 4'd8, v); check("R11 run clear ignored", v, 64'h5);

        // R9 interrupt raise and lower
        wr(8'h60, 4'd4, 64'h5);
        check("R9 irq raised", {63'b0, irq_o}, 64'd1);
        rd(8'h24, 4'd4, v); check("R9 irq status set", v, 64'h5);
        wr(8'h60, 4'd4, 64'h100);
        rd(8'h24, 4'd4, v); check("R9 irq status or", v, 64'h105);
        wr(8'h64, 4'd4, 64'h101);
        check("R9 irq stays while nonzero", {63'b0, irq_o}, 64'd1);
        rd(8'h24, 4'd4, v); check("R9 irq status cleared bits", v, 64'h4);
        wr(8'h64, 4'd4, 64'h4);
        check("R9 irq lowered", {63'b0, irq_o}, 64'd0);

        // R7 enable bit
        wr(8'h20, 4'd4, 64'hFFFF_FF7F);
        rd(8'h20, 4'd4, v); check("R7 enable cleared", v, 64'h0);
        wr(8'h20, 4'd4, 64'h80);
        rd(8'h20, 4'd4, v); check("R7 enable set", v, 64'h80);
        wr(8'h20, 4'd4, 64'h0);

        // R5 R6 factorial sweep, enable clear so R8 expects no interrupt
        for (int n = 0; n <= 13; n++) begin
            wr(8'h08, 4'd4, 64'(n));
            wait_idle();
            rd(8'h08, 4'd4, v); check("R6 factorial result", v, {32'h0, fact_ref(n)});
        end
        rd(8'h24, 4'd4, v); check("R8 no irq with enable clear", v, 64'h0);

        // R5 busy drops writes, operand visible while busy
        wr(8'h08, 4'd4, 64'd12);
        rd(8'h20, 4'd4, v); check("R5 computing set", v & 64'h1, 64'h1);
        rd(8'h08, 4'd4, v); check("R5 operand visible while busy", v, 64'd12);
        wr(8'h08, 4'd4, 64'd5);
        wait_idle();
        rd(8'h08, 4'd4, v); check("R5 write while busy dropped", v, {32'h0, fact_ref(12)});

        // R8 completion interrupt
        wr(8'h20, 4'd4, 64'h80);
        wr(8'h08, 4'd4, 64'd6);
        wait_idle();
        rd(8'h24, 4'd4, v); check("R8 completion sets bit0", v, 64'h1);
        check("R8 irq line on completion", {63'b0, irq_o}, 64'd1);
        rd(8'h08, 4'd4, v); check("R6 result 6!", v, 64'd720);
        wr(8'h64, 4'd4, 64'h1);
        check("R9 irq cleared", {63'b0, irq_o}, 64'd0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule